// File: doc/BRIEF.md
# Correlated Double Sampling Frame Processor

This block turns a stream of digitized detector pixels into correlated double sampled frames. Frames arrive one pixel per valid cycle, and a start flag marks the first pixel of each frame. A phase input, sampled with the start flag, says what the frame is for. A reference frame, taken at the opening of an integration period, is written into a one-frame on-chip memory. A signal frame, taken when the period closes (nominally 30 ms later), is read against that memory one pixel at a time.

For each signal pixel, the block subtracts the stored reference at the same pixel index. A negative result is clamped to zero. Only the upper bits of the unsigned difference go out, which narrows 16-bit samples to 14-bit results. The output stream keeps the input order and carries its own frame-start marker.

The block also watches frame framing. A frame that restarts early, or a pixel that shows up outside any frame, raises a one-cycle truncation pulse, and the pixel index is resynchronized. A signal frame that has no complete reference behind it is dropped, and a sticky error is raised.

Top module: `cds_frame_proc`

## Requirements
- R1: After reset, cds_valid, cds_sof, cds_data, trunc_pulse and noref_err are all 0.
- R2: A frame whose start pixel has pix_phase=0 is a reference frame. Its pixels are stored by index and produce no output.
- R3: For a signal frame (pix_phase=1 at start) pixel with value S, whose stored reference is Rf, cds_data equals bits [15:2] of S-Rf when S>=Rf.
- R4: When S<Rf, cds_data is 0.
- R5: Each processed signal pixel appears on cds_valid exactly 2 clocks after it was accepted, in input order. cds_sof is 1 only on the output of the frame's start pixel.
- R6: A pixel with pix_sof=1 is always index 0. Each following accepted pixel takes the next index, up to 143.
- R7: If no complete reference frame exists when a signal frame starts, that frame produces no output, and noref_err goes to 1 one clock later and stays at 1 until reset.
- R8: A start pixel that arrives while a frame is still open (fewer than 144 pixels received) produces trunc_pulse=1 one clock later, and the new frame starts at index 0.
- R9: A valid pixel without pix_sof after a frame has received all 144 pixels is ignored: it is neither stored nor output, and it produces trunc_pulse=1 one clock later.
- R10: Starting a reference frame invalidates the stored reference until that frame's 144th pixel arrives. A signal frame that follows a truncated reference frame produces no output.
- R11: Cycles with pix_valid=0 do not advance the pixel index or produce output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_sof | input | 1 | First pixel of a frame |
| pix_phase | input | 1 | Integration phase, sampled with pix_sof: 0 = reference, 1 = signal |
| pix_data | input | 16 | Pixel sample |
| cds_valid | output | 1 | Output pixel qualifier |
| cds_sof | output | 1 | First output pixel of a frame |
| cds_data | output | 14 | Clamped, truncated difference |
| trunc_pulse | output | 1 | One-cycle framing error pulse |
| noref_err | output | 1 | Sticky missing-reference error |

## Verification
Two events can land in the same cycle: an early frame start is detected, and the restarted frame's first pixel is handled (stored as reference index 0, or checked against reference validity). The bench provokes this by breaking off a frame partway through with a new start flag, in both phases. It then checks that the truncation pulse appears and that the restarted frame's outputs use index 0. A cycle-by-cycle behavioural model also checks the boundary where a frame's last pixel is followed directly by the next start flag, which must not raise truncation.

// File: rtl/cds_pkg.sv
package cds_pkg;
  localparam int CDS_PIXELS = 144;
  localparam int CDS_IN_W   = 16;
  localparam int CDS_OUT_W  = 14;

  typedef enum logic {PH_REFERENCE = 1'b0, PH_SIGNAL = 1'b1} cds_phase_e;
endpackage

// File: rtl/cds_ref_ram.sv
module cds_ref_ram #(
  parameter int DEPTH = 144,
  parameter int W     = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cds_frame_ctrl.sv
module cds_frame_ctrl
  import cds_pkg::*;
#(
  parameter int PIXELS = 144,
  localparam int AW    = (PIXELS > 1) ? $clog2(PIXELS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_valid,
  input  logic          pix_sof,
  input  logic          pix_phase,
  output logic [AW-1:0] pix_idx,
  output logic          ref_we,
  output logic          sig_fire,
  output logic          trunc_pulse,
  output logic          noref_err
);
  localparam logic [AW-1:0] LAST_IDX = AW'(PIXELS - 1);

  logic [AW-1:0] idx_q;
  logic          in_frame_q;
  cds_phase_e    phase_q;
  logic          frame_ok_q;
  logic          ref_ok_q;

  cds_phase_e cur_phase;
  logic       cur_ok;
  logic       accept;
  logic       is_last;
  logic       framing_err;

  always_comb begin
    pix_idx     = pix_sof ? '0 : idx_q;
    cur_phase   = pix_sof ? cds_phase_e'(pix_phase) : phase_q;
    cur_ok      = pix_sof ? ref_ok_q : frame_ok_q;
    accept      = pix_valid && (pix_sof || in_frame_q);
    is_last     = accept && (pix_idx == LAST_IDX);
    framing_err = pix_valid && (pix_sof == in_frame_q);
    ref_we      = accept && (cur_phase == PH_REFERENCE);
    sig_fire    = accept && (cur_phase == PH_SIGNAL) && cur_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q       <= '0;
      in_frame_q  <= 1'b0;
      phase_q     <= PH_REFERENCE;
      frame_ok_q  <= 1'b0;
      ref_ok_q    <= 1'b0;
      trunc_pulse <= 1'b0;
      noref_err   <= 1'b0;
    end else begin
      trunc_pulse <= framing_err;
      if (accept) begin
        phase_q    <= cur_phase;
        frame_ok_q <= cur_ok;
        if (is_last) begin
          idx_q      <= '0;
          in_frame_q <= 1'b0;
        end else begin
          idx_q      <= pix_idx + 1'b1;
          in_frame_q <= 1'b1;
        end
      end
      if (ref_we) begin
        if (is_last)      ref_ok_q <= 1'b1;
        else if (pix_sof) ref_ok_q <= 1'b0;
      end
      if (accept && pix_sof && cur_phase == PH_SIGNAL && !ref_ok_q)
        noref_err <= 1'b1;
    end
  end
endmodule

// File: rtl/cds_diff_stage.sv
module cds_diff_stage #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  input  logic             s_sof,
  input  logic [IN_W-1:0]  s_sig,
  input  logic [IN_W-1:0]  s_ref,
  output logic             o_valid,
  output logic             o_sof,
  output logic [OUT_W-1:0] o_data
);
  logic [IN_W:0]      diff;
  logic [OUT_W-1:0]   clamped;

  always_comb begin
    diff    = {1'b0, s_sig} - {1'b0, s_ref};
    clamped = diff[IN_W] ? '0 : diff[IN_W-1 -: OUT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_sof   <= 1'b0;
      o_data  <= '0;
    end else begin
      o_valid <= s_valid;
      o_sof   <= s_valid && s_sof;
      if (s_valid) o_data <= clamped;
    end
  end
endmodule

// File: rtl/cds_frame_proc.sv
module cds_frame_proc
  import cds_pkg::*;
#(
  parameter int PIXELS = CDS_PIXELS,
  parameter int IN_W   = CDS_IN_W,
  parameter int OUT_W  = CDS_OUT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid,
  input  logic             pix_sof,
  input  logic             pix_phase,
  input  logic [IN_W-1:0]  pix_data,
  output logic             cds_valid,
  output logic             cds_sof,
  output logic [OUT_W-1:0] cds_data,
  output logic             trunc_pulse,
  output logic             noref_err
);
  localparam int AW = (PIXELS > 1) ? $clog2(PIXELS) : 1;

  logic [AW-1:0]   pix_idx;
  logic            ref_we;
  logic            sig_fire;
  logic [IN_W-1:0] ref_rd;
  logic            s1_valid;
  logic            s1_sof;
  logic [IN_W-1:0] s1_sig;

  cds_frame_ctrl #(.PIXELS(PIXELS)) u_ctrl (
    .clk(clk), .rst(rst),
    .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_phase(pix_phase),
    .pix_idx(pix_idx), .ref_we(ref_we), .sig_fire(sig_fire),
    .trunc_pulse(trunc_pulse), .noref_err(noref_err)
  );

  cds_ref_ram #(.DEPTH(PIXELS), .W(IN_W)) u_ram (
    .clk(clk), .we(ref_we), .waddr(pix_idx), .wdata(pix_data),
    .raddr(pix_idx), .rdata(ref_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sof   <= 1'b0;
      s1_sig   <= '0;
    end else begin
      s1_valid <= sig_fire;
      s1_sof   <= sig_fire && pix_sof;
      if (sig_fire) s1_sig <= pix_data;
    end
  end

  cds_diff_stage #(.IN_W(IN_W), .OUT_W(OUT_W)) u_diff (
    .clk(clk), .rst(rst),
    .s_valid(s1_valid), .s_sof(s1_sof), .s_sig(s1_sig), .s_ref(ref_rd),
    .o_valid(cds_valid), .o_sof(cds_sof), .o_data(cds_data)
  );
endmodule

// File: rtl/cds_frame_sva.sv
module cds_frame_sva (
  input logic clk,
  input logic rst,
  input logic pix_valid,
  input logic pix_sof,
  input logic cds_valid,
  input logic cds_sof,
  input logic trunc_pulse,
  input logic noref_err
);
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    cds_valid |-> $past(pix_valid, 2));

  a_r5_sof_has_valid: assert property (@(posedge clk) disable iff (rst)
    cds_sof |-> cds_valid);

  a_r5_sof_origin: assert property (@(posedge clk) disable iff (rst)
    cds_sof |-> $past(pix_sof, 2));

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    noref_err |=> noref_err);

  a_r8_trunc_cause: assert property (@(posedge clk) disable iff (rst)
    trunc_pulse |-> $past(pix_valid));
endmodule

bind cds_frame_proc cds_frame_sva u_sva (
  .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof),
  .cds_valid(cds_valid), .cds_sof(cds_sof),
  .trunc_pulse(trunc_pulse), .noref_err(noref_err)
);

// File: tb/sim_cds_frame_proc.sv
`timescale 1ns/1ps
module sim_cds_frame_proc;
  localparam int N = 144;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_valid = 1'b0;
  logic        pix_sof = 1'b0;
  logic        pix_phase = 1'b0;
  logic [15:0] pix_data = '0;
  logic        cds_valid, cds_sof, trunc_pulse, noref_err;
  logic [13:0] cds_data;

  int checks = 0;
  int failures = 0;
  int cycle = 0;
  bit done = 0;
  bit cmp_on = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  cds_frame_proc u0 (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_phase(pix_phase), .pix_data(pix_data), .cds_valid(cds_valid),
    .cds_sof(cds_sof), .cds_data(cds_data), .trunc_pulse(trunc_pulse),
    .noref_err(noref_err)
  );

  // behavioural reference model
  int  m_ref [N];
  int  m_idx = 0;
  bit  m_in_frame = 0, m_phase = 0, m_ok = 0, m_ref_ok = 0, m_err = 0;
  bit  s1_v = 0, s1_sof = 0, s1_sat = 0;
  int  s1_d = 0;
  bit  e_v = 0, e_sof = 0, e_sat = 0, e_trunc = 0;
  int  e_d = 0;

  always @(posedge clk) begin
    cycle++;
    if (rst) begin
      m_idx = 0; m_in_frame = 0; m_phase = 0; m_ok = 0; m_ref_ok = 0; m_err = 0;
      s1_v = 0; s1_sof = 0; e_v = 0; e_sof = 0; e_trunc = 0; e_d = 0;
    end else begin
      bit acc;
      e_v = s1_v; e_sof = s1_sof; e_sat = s1_sat;
      if (s1_v) e_d = s1_d;
      s1_v = 0; s1_sof = 0; e_trunc = 0; acc = 0;
      if (pix_valid) begin
        if (pix_sof) begin
          if (m_in_frame) e_trunc = 1;
          m_idx = 0; m_phase = pix_phase; m_in_frame = 1; acc = 1;
          if (!pix_phase) m_ref_ok = 0;
          else begin
            m_ok = m_ref_ok;
            if (!m_ref_ok) m_err = 1;
          end
        end else if (!m_in_frame) e_trunc = 1;
        else acc = 1;
        if (acc) begin
          if (!m_phase) begin
            m_ref[m_idx] = int'(pix_data);
            if (m_idx == N-1) m_ref_ok = 1;
          end else if (m_ok) begin
            s1_v = 1; s1_sof = pix_sof;
            s1_sat = int'(pix_data) < m_ref[m_idx];
            s1_d = s1_sat ? 0 : (int'(pix_data) - m_ref[m_idx]) >> 2;
          end
          m_idx++;
          if (m_idx == N) begin m_idx = 0; m_in_frame = 0; end
        end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (scenario %s)", req, what, act, exp, tag);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(cds_valid == e_v, "R5", "cds_valid", cds_valid, e_v);
      chk(cds_sof == (e_v && e_sof), "R5", "cds_sof", cds_sof, e_v && e_sof);
      if (e_v) chk(int'(cds_data) == e_d, e_sat ? "R4" : "R3", "cds_data", cds_data, e_d);
      chk(trunc_pulse == e_trunc, "R8 R9", "trunc_pulse", trunc_pulse, e_trunc);
      chk(noref_err == m_err, "R7", "noref_err", noref_err, m_err);
    end
  end

  always @(posedge clk) begin
    if (cycle == 100000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic drive(bit v, bit s, bit ph, logic [15:0] d);
    @(negedge clk);
    pix_valid = v; pix_sof = s; pix_phase = ph; pix_data = d;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive(0, 0, 0, 16'h0);
  endtask

  function automatic logic [15:0] ref_px(int i, int f);
    return 16'((i * 521 + f * 97 + 1000) & 16'hFFFF);
  endfunction

  function automatic logic [15:0] sig_px(int i, int f);
    if (i % 7 == 0) return ref_px(i, f) - 16'(i + 1);
    return ref_px(i, f) + 16'((i * 113 + 7 + f * 31) & 16'h3FFF);
  endfunction

  // count pixels; gaps insert idle cycles (R11)
  task automatic frame(bit ph, int f, int cnt, bit gaps);
    for (int i = 0; i < cnt; i++) begin
      drive(1, i == 0, ph, ph ? sig_px(i, f) : ref_px(i, f));
      if (gaps && (i % 5 == 2)) drive(0, 0, 0, 16'hBEEF);
    end
  endtask

  int outs_seen = 0;
  always @(negedge clk) if (cds_valid) outs_seen++;

  initial begin
    idle(3);
    @(negedge clk);
    // R1: reset state
    chk(cds_valid == 0 && cds_sof == 0 && cds_data == 0, "R1", "outputs in reset", cds_valid, 0);
    chk(trunc_pulse == 0 && noref_err == 0, "R1", "flags in reset", noref_err, 0);
    rst = 0;
    cmp_on = 1;
    idle(2);

    tag = "R7 no reference";
    outs_seen = 0;
    frame(1, 0, N, 0); idle(4);
    chk(outs_seen == 0, "R7", "outputs without reference", outs_seen, 0);

    tag = "R2 R11 reference with gaps";
    outs_seen = 0;
    frame(0, 1, N, 1); idle(4);
    chk(outs_seen == 0, "R2", "outputs during reference", outs_seen, 0);

    tag = "R3 R4 R5 R6 signal";
    outs_seen = 0;
    frame(1, 1, N, 1); idle(4);
    chk(outs_seen == N, "R5", "signal output count", outs_seen, N);

    tag = "R5 R6 back-to-back signal";
    outs_seen = 0;
    frame(1, 2, N, 0); frame(1, 3, N, 0); idle(4);
    chk(outs_seen == 2 * N, "R6", "back-to-back output count", outs_seen, 2 * N);

    tag = "R8 early restart signal";
    outs_seen = 0;
    frame(1, 4, 50, 0); frame(1, 5, N, 0); idle(4);
    chk(outs_seen == 50 + N, "R8", "restart output count", outs_seen, 50 + N);

    tag = "R9 stray pixels";
    outs_seen = 0;
    drive(1, 0, 1, 16'h1234); drive(1, 0, 1, 16'hFFFF); idle(4);
    chk(outs_seen == 0, "R9", "stray pixel output", outs_seen, 0);

    tag = "R10 truncated reference";
    outs_seen = 0;
    frame(0, 6, 60, 0); frame(1, 6, N, 0); idle(4);
    chk(outs_seen == 0, "R10", "output after truncated reference", outs_seen, 0);

    tag = "R8 R10 restart inside reference";
    outs_seen = 0;
    frame(0, 7, 30, 1); frame(0, 8, N, 0); frame(1, 8, N, 1); idle(4);
    chk(outs_seen == N, "R10", "output after fresh reference", outs_seen, N);

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule